// File: doc/BRIEF.md
# Dual-Bank IDE PIO Cycle Generator

This block produces the read and write strobes of an IDE programmed-I/O transfer. Each strobe has its own programmable timing. Software loads per-bank timing bytes through an indexed configuration port, and there are two banks. For each bank, one byte governs read cycles and another governs write cycles. A shared miscellaneous register carries three settings: the address setup count, which applies to both drives; a DRDY delay; and a read-prefetch enable. The DRDY delay and the prefetch enable are only stored and presented on output pins.

On the bus side, a request names the direction and the target drive. The generator chooses a bank through a control-register mapping and latches the timing when it accepts the request. It then runs three phases in order:
- an address setup phase;
- a strobe-active phase;
- a strobe-inactive recovery phase.

After recovery it raises a one-cycle completion pulse. It does not take another request until recovery has ended.

Top module: `ide_pio_cyclegen`

## Requirements
- R1: A timing byte holds the strobe-active length minus 1 in bits 7:4 (1 to 16 clocks) and the recovery length minus 2 in bits 3:0 (2 to 17 clocks).
- R2: A read request uses the bank's index-0 byte and pulses `dior_n` low. A write request uses the bank's index-1 byte and pulses `diow_n` low. The two strobes are never low together.
- R3: A write to index 6 stores bit 0 as the bank pointer (0 = bank A, 1 = bank B), and later writes to index 0 or 1 go to that bank. Writes to indices 2, 4, 5 and 7 change nothing.
- R4: A write to index 3 stores bit 0 as the drive-mapping enable. With the enable at 1 (for example 0x85), drive 0 uses bank A and drive 1 uses bank B. With the enable at 0 (for example 0xC0), both drives use bank A.
- R5: Index-6 bits 5:4 hold the address setup length minus 1 (1 to 4 clocks) for both drives. `addr_valid` is high during the setup and active phases and low during recovery.
- R6: `drdy_clks` equals index-6 bits 2:1 plus 2. `prefetch_en` equals index-6 bit 6.
- R7: A cycle runs setup, then active, then recovery, with no gaps. `busy` is high for exactly setup+active+recovery cycles. `done` is high for the single cycle that follows the last recovery cycle.
- R8: A request is taken at a clock edge only when `busy` is low, which includes the `done` cycle. The first setup cycle follows that edge. A request raised while `busy` is high is ignored.
- R9: Timing, bank choice and direction are latched at acceptance. Configuration writes made during a cycle do not alter that cycle.
- R10: Reset (synchronous, active high) clears all registers. After reset `busy`, `done` and `addr_valid` are low, both strobes are high, `prefetch_en` is 0 and `drdy_clks` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Cycle request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_drive | input | 1 | Target drive (0 or 1) |
| busy | output | 1 | Cycle in setup, active or recovery |
| done | output | 1 | One-cycle completion pulse |
| addr_valid | output | 1 | Address/chip-select valid |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| prefetch_en | output | 1 | Stored read-prefetch enable |
| drdy_clks | output | 3 | Stored DRDY delay in clocks |

## Verification
A configuration write lands at its clock edge, so the exported fields are sampled on the falling edge that follows. A request is accepted at the edge after it is raised, and the first setup cycle is visible at the falling edge after that. From then on, the bench classifies every falling edge as setup, active or recovery until `done` appears. It compares each phase's length with the value computed from the fields it programmed. Any sample that fits none of these phases is counted as an ordering error. The tests of ignored requests and of writes made during a cycle are sampled at the same edges, and they also check that no cycle starts in the cycles after `done`.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int IDX_W = 3;
    localparam logic [IDX_W-1:0] IDX_RD_CYC  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_WR_CYC  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CTRL    = 3'd3;
    localparam logic [IDX_W-1:0] IDX_MISC    = 3'd6;

    // One timing byte: active length minus 1, recovery length minus 2
    typedef struct packed {
        logic [3:0] act_m1;
        logic [3:0] rec_m2;
    } cyc_byte_t;

    // Timing selected for one cycle
    typedef struct packed {
        logic [1:0] setup_m1;
        logic [3:0] act_m1;
        logic [3:0] rec_m2;
    } cyc_timing_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV,
        PH_DONE
    } phase_e;

    // Counter load value for recovery: (rec_m2 + 2) - 1
    function automatic logic [4:0] rec_load(input logic [3:0] rec_m2);
        return {1'b0, rec_m2} + 5'd1;
    endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import ide_pio_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [7:0]       cfg_wdata,
    output cyc_byte_t        rd_byte [NUM_BANKS],
    output cyc_byte_t        wr_byte [NUM_BANKS],
    output logic             map_en,
    output logic [1:0]       setup_m1,
    output logic [1:0]       drdy_m2,
    output logic             prefetch
);

    logic [BANK_W-1:0] bank_ptr_q;

    // Shared miscellaneous fields and bank pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            bank_ptr_q <= '0;
            setup_m1   <= '0;
            drdy_m2    <= '0;
            prefetch   <= 1'b0;
        end else if (cfg_we && cfg_idx == IDX_MISC) begin
            bank_ptr_q <= cfg_wdata[BANK_W-1:0];
            setup_m1   <= cfg_wdata[5:4];
            drdy_m2    <= cfg_wdata[2:1];
            prefetch   <= cfg_wdata[6];
        end
    end

    // Drive-to-bank mapping enable
    always_ff @(posedge clk) begin
        if (rst) begin
            map_en <= 1'b0;
        end else if (cfg_we && cfg_idx == IDX_CTRL) begin
            map_en <= cfg_wdata[0];
        end
    end

    // One read and one write timing byte per bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_hit;
        assign bank_hit = cfg_we && (bank_ptr_q == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_byte[b] <= '0;
                wr_byte[b] <= '0;
            end else if (bank_hit) begin
                if (cfg_idx == IDX_RD_CYC) rd_byte[b] <= cyc_byte_t'(cfg_wdata);
                if (cfg_idx == IDX_WR_CYC) wr_byte[b] <= cyc_byte_t'(cfg_wdata);
            end
        end
    end

endmodule

// File: rtl/pio_bank_select.sv
module pio_bank_select
    import ide_pio_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  cyc_byte_t   rd_byte [NUM_BANKS],
    input  cyc_byte_t   wr_byte [NUM_BANKS],
    input  logic        map_en,
    input  logic [1:0]  setup_m1,
    input  logic        req_write,
    input  logic        req_drive,
    output cyc_timing_t timing
);

    logic [BANK_W-1:0] bank;
    cyc_byte_t         pick;

    always_comb begin
        bank = map_en ? BANK_W'(req_drive) : '0;
        pick = req_write ? wr_byte[bank] : rd_byte[bank];
        timing.setup_m1 = setup_m1;
        timing.act_m1   = pick.act_m1;
        timing.rec_m2   = pick.rec_m2;
    end

endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
    import ide_pio_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  cyc_timing_t timing,
    output logic        busy,
    output logic        done,
    output logic        addr_valid,
    output logic        dior_n,
    output logic        diow_n
);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    cyc_timing_t       tim_q;
    logic              wr_q;
    logic              accept;
    logic              cnt_zero;

    assign accept   = req_valid && (phase_q == PH_IDLE || phase_q == PH_DONE);
    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            tim_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE, PH_DONE: begin
                    if (accept) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= CNT_W'(timing.setup_m1);
                        tim_q   <= timing;
                        wr_q    <= req_write;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase_q <= PH_ACTIVE;
                        cnt_q   <= CNT_W'(tim_q.act_m1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (cnt_zero) begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= CNT_W'(rec_load(tim_q.rec_m2));
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (cnt_zero) begin
                        phase_q <= PH_DONE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (phase_q == PH_SETUP) || (phase_q == PH_ACTIVE) || (phase_q == PH_RECOV);
        done       = (phase_q == PH_DONE);
        addr_valid = (phase_q == PH_SETUP) || (phase_q == PH_ACTIVE);
        dior_n     = !((phase_q == PH_ACTIVE) && !wr_q);
        diow_n     = !((phase_q == PH_ACTIVE) && wr_q);
    end

endmodule

// File: rtl/ide_pio_cyclegen.sv
module ide_pio_cyclegen
    import ide_pio_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [7:0]       cfg_wdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_drive,
    output logic             busy,
    output logic             done,
    output logic             addr_valid,
    output logic             dior_n,
    output logic             diow_n,
    output logic             prefetch_en,
    output logic [2:0]       drdy_clks
);

    cyc_byte_t   rd_byte [NUM_BANKS];
    cyc_byte_t   wr_byte [NUM_BANKS];
    logic        map_en;
    logic [1:0]  setup_m1;
    logic [1:0]  drdy_m2;
    cyc_timing_t timing;

    pio_cfg_regs #(.NUM_BANKS(NUM_BANKS)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .rd_byte   (rd_byte),
        .wr_byte   (wr_byte),
        .map_en    (map_en),
        .setup_m1  (setup_m1),
        .drdy_m2   (drdy_m2),
        .prefetch  (prefetch_en)
    );

    pio_bank_select #(.NUM_BANKS(NUM_BANKS)) i_sel (
        .rd_byte   (rd_byte),
        .wr_byte   (wr_byte),
        .map_en    (map_en),
        .setup_m1  (setup_m1),
        .req_write (req_write),
        .req_drive (req_drive),
        .timing    (timing)
    );

    pio_cycle_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .timing     (timing),
        .busy       (busy),
        .done       (done),
        .addr_valid (addr_valid),
        .dior_n     (dior_n),
        .diow_n     (diow_n)
    );

    assign drdy_clks = {1'b0, drdy_m2} + 3'd2;

endmodule

// File: rtl/pio_cyclegen_chk.sv
module pio_cyclegen_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic addr_valid,
    input logic dior_n,
    input logic diow_n
);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    // R5
    strobe_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!dior_n || !diow_n) |-> (addr_valid && busy));

    // R5
    recov_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !addr_valid) |-> (dior_n && diow_n));

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !addr_valid && dior_n && diow_n));

endmodule

bind ide_pio_cyclegen pio_cyclegen_chk i_chk (.*);

// File: tb/test_ide_pio_cyclegen.sv
module test_ide_pio_cyclegen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = 3'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_drive = 1'b0;
    logic       busy, done, addr_valid, dior_n, diow_n, prefetch_en;
    logic [2:0] drdy_clks;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ide_pio_cyclegen i_ide_pio_cyclegen (
        .clk, .rst, .cfg_we, .cfg_idx, .cfg_wdata,
        .req_valid, .req_write, .req_drive,
        .busy, .done, .addr_valid, .dior_n, .diow_n,
        .prefetch_en, .drdy_clks
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request and measure its phases at falling edges
    task automatic run_cycle(input bit drv, input bit wr, input int es, input int ed,
                             input int er, input string tg);
        int s = 0, d = 0, r = 0, bad = 0, guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_drive = drv;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && guard < 100) begin
            if (busy && addr_valid && dior_n && diow_n && d == 0) s++;
            else if (busy && addr_valid && (wr ? (!diow_n && dior_n) : (!dior_n && diow_n))) d++;
            else if (busy && !addr_valid && dior_n && diow_n) r++;
            else bad++;
            guard++;
            @(negedge clk);
        end
        chk(s == es, "R5 setup", s, es);
        chk(d == ed, {tg, " active"}, d, ed);
        chk(r == er, {tg, " recovery"}, r, er);
        chk(bad == 0 && done, "R7 order", bad, 0);
        @(negedge clk);
        chk(!done && !busy, "R7 done pulse", int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !addr_valid, "R10 idle", int'(busy), 0);
        chk(dior_n && diow_n, "R10 strobes", int'({dior_n, diow_n}), 3);
        chk(prefetch_en == 1'b0, "R10 prefetch", int'(prefetch_en), 0);
        chk(drdy_clks == 3'd2, "R10 drdy", int'(drdy_clks), 2);
        run_cycle(1'b0, 1'b0, 1, 1, 2, "R10 default");

        // R6 exported misc fields
        cfg_write(3'd6, 8'h46);
        chk(prefetch_en == 1'b1, "R6 prefetch", int'(prefetch_en), 1);
        chk(drdy_clks == 3'd5, "R6 drdy", int'(drdy_clks), 5);
        cfg_write(3'd6, 8'h02);
        chk(prefetch_en == 1'b0, "R6 prefetch off", int'(prefetch_en), 0);
        chk(drdy_clks == 3'd3, "R6 drdy", int'(drdy_clks), 3);

        // R1 R2 R3 R4 R5 sweep over timing fields and mapping mode
        for (int m = 0; m < 2; m++) begin
            for (int sf = 0; sf < 4; sf++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    for (int ri = 0; ri < 4; ri++) begin
                        int pf, rf;
                        pf = pi * 5;
                        rf = ri * 5;
                        cfg_write(3'd6, 8'(sf << 4));
                        cfg_write(3'd0, {4'(pf), 4'(rf)});
                        cfg_write(3'd1, {4'(rf), 4'(pf)});
                        cfg_write(3'd6, 8'((sf << 4) | 1));
                        cfg_write(3'd0, {4'(15 - pf), 4'(15 - rf)});
                        cfg_write(3'd1, {4'(15 - rf), 4'(15 - pf)});
                        cfg_write(3'd3, (m != 0) ? 8'h85 : 8'hC0);
                        run_cycle(1'b0, 1'b0, sf + 1, pf + 1, rf + 2, "R1");
                        run_cycle(1'b0, 1'b1, sf + 1, rf + 1, pf + 2, "R2");
                        if (m != 0) begin
                            run_cycle(1'b1, 1'b0, sf + 1, 16 - pf, 17 - rf, "R3");
                            run_cycle(1'b1, 1'b1, sf + 1, 16 - rf, 17 - pf, "R3");
                        end else begin
                            run_cycle(1'b1, 1'b0, sf + 1, pf + 1, rf + 2, "R4");
                            run_cycle(1'b1, 1'b1, sf + 1, rf + 1, pf + 2, "R4");
                        end
                    end
                end
            end
        end

        // R3 unused indices change nothing
        cfg_write(3'd6, 8'h10);
        cfg_write(3'd0, 8'h32);
        cfg_write(3'd3, 8'hC0);
        cfg_write(3'd2, 8'hFF);
        cfg_write(3'd4, 8'hFF);
        cfg_write(3'd5, 8'hFF);
        cfg_write(3'd7, 8'hFF);
        run_cycle(1'b0, 1'b0, 2, 4, 4, "R3 ignored idx");
        run_cycle(1'b1, 1'b0, 2, 4, 4, "R3 ignored idx");

        // R9 config writes during a cycle do not alter it
        cfg_write(3'd6, 8'h30);
        cfg_write(3'd0, 8'h77);
        fork
            run_cycle(1'b0, 1'b0, 4, 8, 9, "R9");
            begin
                repeat (4) @(negedge clk);
                cfg_write(3'd0, 8'h00);
                cfg_write(3'd6, 8'h00);
            end
        join
        run_cycle(1'b0, 1'b0, 1, 1, 2, "R9 new values");

        // R8 request while busy ignored
        cfg_write(3'd6, 8'h30);
        cfg_write(3'd0, 8'h77);
        fork
            run_cycle(1'b0, 1'b0, 4, 8, 9, "R8");
            begin
                repeat (3) @(negedge clk);
                req_valid = 1'b1; req_write = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!busy && !done, "R8 no late start", int'(busy), 0);
        end

        // R8 acceptance in the done cycle
        cfg_write(3'd0, 8'h00);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_drive = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && addr_valid, "R8 setup after accept", int'(busy), 1);
        while (!done) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && addr_valid && !done, "R8 accept in done", int'(busy), 1);
        repeat (6) @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule